// File: doc/BRIEF.md
# Link Exchange Startup and Credit Controller

This block is the exchange-level sequencer for one full-duplex serial link. It walks the link through a fixed recovery and startup handshake: a timed reset hold, a timed wait, an idle ready state, a phase that sends only nulls, a phase that sends nulls and flow-control tokens, and finally the running state in which every character may go out. Any receive fault, or a character that comes too early, sends the link back to the reset hold. After that the whole sequence runs again.

Credit is kept in both directions, in units of eight characters per flow-control token. The transmit side counts what the far end has granted. It gives the character serializer a send permit while that count is non-zero. The receive side counts what has been promised to the far end. It asks for another token only when the receive buffer can hold eight more characters beyond that promise. Serialization and the host side lie outside this block.

Top module: `lnk_exchange_ctl`

## Requirements
- R1: While reset is held, and in the cycle after release, `linkState` is 0 and `txNullEn`, `txFctEn`, `txAllEn`, `fctReq`, `txPermit` and `linkUp` are all low. The state codes are: hold 0, wait 1, ready 2, started 3, connecting 4, run 5.
- R2: The hold state (0) lasts exactly `RST_CYC` cycles and then gives way to wait (1). Receive events and faults seen during the hold have no effect on its length. Wait lasts exactly `WAIT_CYC` cycles, and then the state goes to ready (2).
- R3: In wait, ready or started, a fault input, `rxFct` or `rxData` sends the state to 0 on the next cycle. In connecting, a fault or `rxData` does the same.
- R4: Ready stays in place for as long as `linkStart` is low. With `linkStart` high it moves to started (3). There, only `txNullEn` is high and `fctReq` stays low.
- R5: Started moves to connecting (4) once a null has been received at any time after the last hold. Connecting raises `txNullEn` and `txFctEn`, but not `txAllEn`.
- R6: If started or connecting does not advance within `TMO_CYC` cycles, the state goes to 0.
- R7: `rxFct` in connecting moves the state to run (5) with a transmit credit of 8. Run raises `txAllEn` and `linkUp`.
- R8: `txPermit` is high only in run with non-zero transmit credit. Each cycle with `txDataSent` and `txPermit` both high uses one unit of credit.
- R9: Each `rxFct` in run adds 8 to the transmit credit, up to 56. A token that would take the credit above 56 sends the state to 0. All credit is cleared in the hold state.
- R10: In connecting and run, `fctReq` is high exactly when promised receive credit P satisfies P+8 <= 56 and `rxFree` >= P+8. A cycle with both `txFctSent` and `fctReq` high adds 8 to P.
- R11: Each `rxData` in run uses one unit of promised credit. `rxData` while the promised credit is 0 sends the state to 0.
- R12: A parity (`rxParErr`), escape (`rxEscErr`) or disconnect (`rxDiscErr`) fault in run sends the state to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| linkStart | input | 1 | Request to leave ready and start the link |
| rxNull | input | 1 | Receiver saw a null |
| rxFct | input | 1 | Receiver saw a flow-control token |
| rxData | input | 1 | Receiver saw a data or end-of-packet character |
| rxParErr | input | 1 | Receiver parity fault |
| rxEscErr | input | 1 | Receiver illegal escape sequence |
| rxDiscErr | input | 1 | Receiver disconnect timeout |
| rxFree | input | FREE_W | Free character slots in the receive buffer |
| txFctSent | input | 1 | Transmitter sent the requested token |
| txDataSent | input | 1 | Transmitter sent a data or end-of-packet character |
| txNullEn | output | 1 | Transmitter may send nulls |
| txFctEn | output | 1 | Transmitter may send tokens |
| txAllEn | output | 1 | Transmitter may send every character type |
| fctReq | output | 1 | Request to send one flow-control token |
| txPermit | output | 1 | A data character may go out this cycle |
| linkUp | output | 1 | Link is in run |
| linkState | output | 3 | Current state code |

## Verification
State changes and credit updates are registered, so an input event becomes visible at the outputs one clock edge after the cycle in which it is driven. `fctReq` depends combinationally on `rxFree` and is due in the same cycle. The bench drives inputs one time unit after a rising edge and reads outputs right after the next edge. A settle delay is added only before same-cycle `fctReq` checks. The timed phases are checked on every cycle of their span, so an off-by-one shows up at the exact edge. The token request rule is swept over every buffer level at each credit step.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  typedef enum logic [2:0] {
    ST_HOLD    = 3'd0,
    ST_WAIT    = 3'd1,
    ST_READY   = 3'd2,
    ST_STARTED = 3'd3,
    ST_CONNECT = 3'd4,
    ST_RUN     = 3'd5
  } lnkState_t;

  // strobes from the sequencer to the credit datapath
  typedef struct packed {
    logic clrCredit;  // wipe both credit counters
    logic takeFct;    // an incoming token is accepted this cycle
    logic takeData;   // an incoming data character is accepted this cycle
    logic fctWindow;  // outgoing tokens are allowed
    logic runMode;    // outgoing data is allowed
  } credStrobe_t;

endpackage

// File: rtl/lnk_fsm.sv
module lnk_fsm
  import lnk_pkg::*;
#(
  parameter int RST_CYC  = 64,
  parameter int WAIT_CYC = 128,
  parameter int TMO_CYC  = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        linkStart,
  input  logic        rxNull,
  input  logic        rxFct,
  input  logic        rxData,
  input  logic        rxParErr,
  input  logic        rxEscErr,
  input  logic        rxDiscErr,
  input  logic        txOvf,
  input  logic        rxUnder,
  output lnkState_t   stCur,
  output credStrobe_t strobe
);

  localparam int MAX_A   = (RST_CYC > WAIT_CYC) ? RST_CYC : WAIT_CYC;
  localparam int CNT_MAX = (MAX_A > TMO_CYC) ? MAX_A : TMO_CYC;
  localparam int CNTW    = $clog2(CNT_MAX + 1);
  localparam logic [CNTW-1:0] RST_END  = CNTW'(RST_CYC - 1);
  localparam logic [CNTW-1:0] WAIT_END = CNTW'(WAIT_CYC - 1);
  localparam logic [CNTW-1:0] TMO_END  = CNTW'(TMO_CYC - 1);
  localparam logic [CNTW-1:0] CNT_TOP  = CNTW'(CNT_MAX);

  lnkState_t       stNext;
  logic [CNTW-1:0] dwell;
  logic            seenNull;
  logic            rxFault;
  logic            earlyChar;

  assign rxFault   = rxParErr | rxEscErr | rxDiscErr;
  assign earlyChar = rxFct | rxData;

  always_comb begin
    stNext = stCur;
    unique case (stCur)
      ST_HOLD:    if (dwell == RST_END) stNext = ST_WAIT;
      ST_WAIT: begin
        if (rxFault || earlyChar)    stNext = ST_HOLD;
        else if (dwell == WAIT_END)  stNext = ST_READY;
      end
      ST_READY: begin
        if (rxFault || earlyChar)    stNext = ST_HOLD;
        else if (linkStart)          stNext = ST_STARTED;
      end
      ST_STARTED: begin
        if (rxFault || earlyChar)    stNext = ST_HOLD;
        else if (seenNull || rxNull) stNext = ST_CONNECT;
        else if (dwell == TMO_END)   stNext = ST_HOLD;
      end
      ST_CONNECT: begin
        if (rxFault || rxData)       stNext = ST_HOLD;
        else if (rxFct)              stNext = ST_RUN;
        else if (dwell == TMO_END)   stNext = ST_HOLD;
      end
      ST_RUN: begin
        if (rxFault || txOvf || rxUnder) stNext = ST_HOLD;
      end
      default: stNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stCur <= ST_HOLD;
      dwell <= '0;
    end else begin
      stCur <= stNext;
      if (stNext != stCur)     dwell <= '0;
      else if (dwell != CNT_TOP) dwell <= dwell + 1'b1;
    end
  end

  // a null counts from the end of the hold onward
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  seenNull <= 1'b0;
    else if (stCur == ST_HOLD)  seenNull <= 1'b0;
    else if (rxNull)            seenNull <= 1'b1;
  end

  always_comb begin
    strobe.clrCredit = (stCur == ST_HOLD);
    strobe.fctWindow = (stCur == ST_CONNECT) || (stCur == ST_RUN);
    strobe.runMode   = (stCur == ST_RUN);
    strobe.takeFct   = rxFct && strobe.fctWindow;
    strobe.takeData  = rxData && strobe.runMode;
  end

endmodule

// File: rtl/lnk_credit.sv
module lnk_credit
  import lnk_pkg::*;
#(
  parameter int CREDIT_MAX = 56,
  parameter int TOKEN      = 8,
  parameter int FREE_W     = 7,
  localparam int CW        = $clog2(CREDIT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  credStrobe_t       strobe,
  input  logic              txFctSent,
  input  logic              txDataSent,
  input  logic [FREE_W-1:0] rxFree,
  output logic [CW-1:0]     txCredit,
  output logic [CW-1:0]     rxCredit,
  output logic              txOvf,
  output logic              rxUnder,
  output logic              fctReq,
  output logic              txPermit
);

  localparam int SW = ((CW > FREE_W) ? CW : FREE_W) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(CREDIT_MAX - TOKEN);
  localparam logic [CW-1:0] STEP  = CW'(TOKEN);

  logic [SW-1:0] roomNeed;
  logic          txUse;
  logic          rxGrant;
  logic          rxUse;

  assign txOvf    = strobe.takeFct && (txCredit > LIMIT);
  assign txPermit = strobe.runMode && (txCredit != '0);
  assign txUse    = txDataSent && txPermit;

  assign rxUnder  = strobe.takeData && (rxCredit == '0);
  assign rxUse    = strobe.takeData && !rxUnder;
  assign roomNeed = SW'(rxCredit) + SW'(TOKEN);
  assign fctReq   = strobe.fctWindow && (rxCredit <= LIMIT) && (SW'(rxFree) >= roomNeed);
  assign rxGrant  = txFctSent && fctReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCredit <= '0;
      rxCredit <= '0;
    end else if (strobe.clrCredit) begin
      txCredit <= '0;
      rxCredit <= '0;
    end else begin
      txCredit <= txCredit + ((strobe.takeFct && !txOvf) ? STEP : '0) - CW'(txUse);
      rxCredit <= rxCredit + (rxGrant ? STEP : '0) - CW'(rxUse);
    end
  end

endmodule

// File: rtl/lnk_exchange_ctl.sv
module lnk_exchange_ctl
  import lnk_pkg::*;
#(
  parameter int RST_CYC    = 64,
  parameter int WAIT_CYC   = 128,
  parameter int TMO_CYC    = 128,
  parameter int CREDIT_MAX = 56,
  parameter int TOKEN      = 8,
  parameter int FREE_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkStart,
  input  logic              rxNull,
  input  logic              rxFct,
  input  logic              rxData,
  input  logic              rxParErr,
  input  logic              rxEscErr,
  input  logic              rxDiscErr,
  input  logic [FREE_W-1:0] rxFree,
  input  logic              txFctSent,
  input  logic              txDataSent,
  output logic              txNullEn,
  output logic              txFctEn,
  output logic              txAllEn,
  output logic              fctReq,
  output logic              txPermit,
  output logic              linkUp,
  output logic [2:0]        linkState
);

  localparam int CW = $clog2(CREDIT_MAX + 1);

  lnkState_t     stCur;
  credStrobe_t   strobe;
  logic          txOvf;
  logic          rxUnder;
  logic [CW-1:0] txCredit;
  logic [CW-1:0] rxCredit;

  lnk_fsm #(
    .RST_CYC (RST_CYC),
    .WAIT_CYC(WAIT_CYC),
    .TMO_CYC (TMO_CYC)
  ) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .linkStart(linkStart),
    .rxNull   (rxNull),
    .rxFct    (rxFct),
    .rxData   (rxData),
    .rxParErr (rxParErr),
    .rxEscErr (rxEscErr),
    .rxDiscErr(rxDiscErr),
    .txOvf    (txOvf),
    .rxUnder  (rxUnder),
    .stCur    (stCur),
    .strobe   (strobe)
  );

  lnk_credit #(
    .CREDIT_MAX(CREDIT_MAX),
    .TOKEN     (TOKEN),
    .FREE_W    (FREE_W)
  ) u_credit (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .txFctSent (txFctSent),
    .txDataSent(txDataSent),
    .rxFree    (rxFree),
    .txCredit  (txCredit),
    .rxCredit  (rxCredit),
    .txOvf     (txOvf),
    .rxUnder   (rxUnder),
    .fctReq    (fctReq),
    .txPermit  (txPermit)
  );

  assign txNullEn  = (stCur == ST_STARTED) || strobe.fctWindow;
  assign txFctEn   = strobe.fctWindow;
  assign txAllEn   = strobe.runMode;
  assign linkUp    = strobe.runMode;
  assign linkState = stCur;

endmodule

// File: rtl/lnk_exchange_chk.sv
module lnk_exchange_chk #(
  parameter int RST_CYC    = 64,
  parameter int WAIT_CYC   = 128,
  parameter int TMO_CYC    = 128,
  parameter int CREDIT_MAX = 56,
  parameter int CW         = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic [2:0]    linkState,
  input logic          rxFct,
  input logic          rxParErr,
  input logic          rxEscErr,
  input logic          rxDiscErr,
  input logic [CW-1:0] txCredit
);

  logic [2:0]  prevS;
  logic [31:0] lenR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevS <= 3'd0;
      lenR  <= 32'd0;
    end else begin
      prevS <= linkState;
      if (linkState != prevS)     lenR <= 32'd1;
      else if (lenR != 32'hFFFF_FFFF) lenR <= lenR + 32'd1;
    end
  end

  // R2
  hold_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevS == 3'd0 && linkState != 3'd0) |-> (lenR == 32'(RST_CYC)));

  // R2
  wait_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevS == 3'd1 && linkState == 3'd2) |-> (lenR == 32'(WAIT_CYC)));

  // R6
  started_tmo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevS == 3'd3 && lenR >= 32'(TMO_CYC)) |-> (linkState != 3'd3));

  // R6
  connect_tmo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevS == 3'd4 && lenR >= 32'(TMO_CYC)) |-> (linkState != 3'd4));

  // R3
  ready_early_fct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == 3'd2 && rxFct) |=> (linkState == 3'd0));

  // R7
  connect_to_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == 3'd4 && rxFct && !rxParErr && !rxEscErr && !rxDiscErr) |=> (linkState == 3'd5));

  // R12
  run_disc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == 3'd5 && rxDiscErr) |=> (linkState == 3'd0));

  // R9
  credit_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (32'(txCredit) <= 32'(CREDIT_MAX)));

  // R9
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == 3'd0) |=> (txCredit == '0));

endmodule

bind lnk_exchange_ctl lnk_exchange_chk #(
  .RST_CYC   (RST_CYC),
  .WAIT_CYC  (WAIT_CYC),
  .TMO_CYC   (TMO_CYC),
  .CREDIT_MAX(CREDIT_MAX),
  .CW        (CW)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .linkState(linkState),
  .rxFct    (rxFct),
  .rxParErr (rxParErr),
  .rxEscErr (rxEscErr),
  .rxDiscErr(rxDiscErr),
  .txCredit (txCredit)
);

// File: tb/lnk_exchange_ctl_bench.sv
module lnk_exchange_ctl_bench;

  localparam int CLK_P  = 10;
  localparam int RST_C  = 4;
  localparam int WAIT_C = 6;
  localparam int TMO_C  = 5;
  localparam int CMAX   = 56;
  localparam int FW     = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linkStart = 0, rxNull = 0, rxFct = 0, rxData = 0;
  logic rxParErr = 0, rxEscErr = 0, rxDiscErr = 0;
  logic [FW-1:0] rxFree = '0;
  logic txFctSent = 0, txDataSent = 0;
  logic txNullEn, txFctEn, txAllEn, fctReq, txPermit, linkUp;
  logic [2:0] linkState;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  lnk_exchange_ctl #(
    .RST_CYC(RST_C), .WAIT_CYC(WAIT_C), .TMO_CYC(TMO_C),
    .CREDIT_MAX(CMAX), .TOKEN(8), .FREE_W(FW)
  ) u_lnk_exchange_ctl (
    .clk(clk), .rstN(rstN), .linkStart(linkStart), .rxNull(rxNull),
    .rxFct(rxFct), .rxData(rxData), .rxParErr(rxParErr), .rxEscErr(rxEscErr),
    .rxDiscErr(rxDiscErr), .rxFree(rxFree), .txFctSent(txFctSent),
    .txDataSent(txDataSent), .txNullEn(txNullEn), .txFctEn(txFctEn),
    .txAllEn(txAllEn), .fctReq(fctReq), .txPermit(txPermit), .linkUp(linkUp),
    .linkState(linkState)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic waitState(input int target);
    for (int i = 0; i < 300 && int'(linkState) != target; i++) tick();
    check("wait for state", int'(linkState), target);
  endtask

  task automatic bringUp();
    linkStart = 1;
    waitState(3);
    rxNull = 1; tick(); rxNull = 0;
    check("R5 connecting", int'(linkState), 4);
    rxFct = 1; tick(); rxFct = 0;
    check("R7 run", int'(linkState), 5);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 during reset
    check("R1 state", int'(linkState), 0);
    check("R1 enables", int'({txNullEn, txFctEn, txAllEn, fctReq, txPermit, linkUp}), 0);
    rstN = 1;
    // R1 right after release
    check("R1 state after release", int'(linkState), 0);
    // R2 faults during hold are ignored
    rxParErr = 1; rxFct = 1; rxData = 1;
    for (int k = 1; k <= RST_C + WAIT_C; k++) begin
      tick();
      rxParErr = 0; rxFct = 0; rxData = 0;
      check("R2 phase timing", int'(linkState), (k < RST_C) ? 0 : (k < RST_C + WAIT_C) ? 1 : 2);
    end
    // R4 ready holds without start
    repeat (15) tick();
    check("R4 ready hold", int'(linkState), 2);
    check("R4 no null in ready", int'(txNullEn), 0);
    // R3 token in ready
    rxFct = 1; tick(); rxFct = 0;
    check("R3 fct in ready", int'(linkState), 0);
    // R3 escape fault in wait
    waitState(1);
    rxEscErr = 1; tick(); rxEscErr = 0;
    check("R3 fault in wait", int'(linkState), 0);
    // R4 start, then R6 started timeout
    waitState(2);
    linkStart = 1; tick();
    check("R4 started", int'(linkState), 3);
    check("R4 null only", int'({txNullEn, txFctEn, txAllEn}), 4);
    rxFree = '1; #1;
    check("R4 no fct request", int'(fctReq), 0);
    for (int k = 1; k <= TMO_C; k++) begin
      tick();
      check("R6 started timeout", int'(linkState), (k < TMO_C) ? 3 : 0);
    end
    // R5 and R6 connecting timeout
    waitState(3);
    rxNull = 1; tick(); rxNull = 0;
    check("R5 connecting", int'(linkState), 4);
    check("R5 enables", int'({txNullEn, txFctEn, txAllEn}), 6);
    check("R10 request in connecting", int'(fctReq), 1);
    for (int k = 1; k <= TMO_C; k++) begin
      tick();
      check("R6 connecting timeout", int'(linkState), (k < TMO_C) ? 4 : 0);
    end
    // R3 data in connecting
    waitState(3);
    rxNull = 1; tick(); rxNull = 0;
    rxData = 1; tick(); rxData = 0;
    check("R3 data in connecting", int'(linkState), 0);
    // R7 and R8
    rxFree = '0;
    bringUp();
    check("R7 link up", int'({linkUp, txAllEn, txPermit}), 7);
    txDataSent = 1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      check("R8 permit after sends", int'(txPermit), (k < 8) ? 1 : 0);
    end
    tick();
    check("R8 no credit left", int'(txPermit), 0);
    txDataSent = 0;
    // R9 fill to 56 and count it back out
    for (int k = 1; k <= 7; k++) begin
      rxFct = 1; tick(); rxFct = 0;
      check("R9 token accepted", int'(linkState), 5);
    end
    begin
      int spent = 0;
      txDataSent = 1;
      for (int i = 0; i < 80 && txPermit; i++) begin tick(); spent++; end
      txDataSent = 0;
      check("R9 credit total", spent, 56);
    end
    for (int k = 1; k <= 7; k++) begin rxFct = 1; tick(); rxFct = 0; end
    check("R9 at cap still run", int'(linkState), 5);
    rxFct = 1; tick(); rxFct = 0;
    check("R9 over cap", int'(linkState), 0);
    // R10 request sweep
    bringUp();
    for (int p = 0; p <= CMAX; p += 8) begin
      for (int f = 0; f < (1 << FW); f++) begin
        rxFree = FW'(f); #1;
        check("R10 request rule", int'(fctReq), (p + 8 <= CMAX && f >= p + 8) ? 1 : 0);
      end
      rxFree = '1;
      txFctSent = 1; tick(); txFctSent = 0;
    end
    // R11 use promised credit, then one too many
    for (int k = 1; k <= CMAX; k++) begin
      rxData = 1; tick();
      check("R11 data within credit", int'(linkState), 5);
    end
    tick(); rxData = 0;
    check("R11 data beyond credit", int'(linkState), 0);
    // R12 faults in run
    bringUp();
    rxDiscErr = 1; tick(); rxDiscErr = 0;
    check("R12 disconnect", int'(linkState), 0);
    bringUp();
    rxParErr = 1; tick(); rxParErr = 0;
    check("R12 parity", int'(linkState), 0);
    bringUp();
    rxEscErr = 1; tick(); rxEscErr = 0;
    check("R12 escape", int'(linkState), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule